// File: doc/BRIEF.md
# Dual-Master Hardware Semaphore Bank

This block holds a set of 2-bit ownership fields that two bus masters, A and B, use to arbitrate shared resources without software locking. Each master has its own write port: the port a write arrives on identifies the writer. A field reads 00 when free, 01 when master A holds it and 10 when master B holds it. Once a field holds a nonzero value, only a release write of 00 changes it. Any other write to a held field is dropped.

The bank contains NUM_RES single-field resource semaphores at register indices 0 to NUM_RES-1. It also contains one group-ownership register at index NUM_RES, which packs NUM_GRP fields. In that register, the code 11 in a field means "leave this field alone", so a master can claim or release one group without touching the others.

All fields are visible at once on a packed status output. A second packed output records, for every field, the value that field held before its most recent change. A combinational read port returns one register chosen by index.

Top module: `hw_sema_bank`

## Requirements
- R1: After reset, every status slice and every previous-owner slice is 00.
- R2: A write to a free field (00) loads the written 2-bit code into it. Single-field registers take their code from data bits [1:0].
- R3: A write of any nonzero code to a field that is not 00 leaves the field unchanged.
- R4: A write of 00 to a held field releases it to 00, whichever master writes it.
- R5: In the group register (index NUM_RES), group field k is written from data bits [2k+1:2k], and a code of 11 leaves that field unchanged. Every other code follows R2 to R4 for each field on its own. For example, data 10'b11_1111_1011 claims group field 1 for the writer and touches no other field.
- R6: Field j occupies status bits [2j+1:2j]. Single semaphores come first (j = 0 to NUM_RES-1), then group field k at j = NUM_RES+k. Each slice updates one clock after the write.
- R7: The previous-owner slice of a field takes the field's old value in the cycle that the field's value changes. It holds its value otherwise, including on ignored writes.
- R8: When both masters write the same field in one cycle, master A's write is applied first, and master B's write is then judged against that result.
- R9: rd_data combinationally returns the field of single semaphore i in bits [1:0] (upper bits zero) for index i < NUM_RES. It returns the whole packed group register for index NUM_RES, and zero for any larger index.
- R10: A write whose index is greater than NUM_RES changes no field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_wr_en | input | 1 | Master A write strobe |
| a_wr_idx | input | IDX_W | Master A register index |
| a_wr_data | input | DATA_W | Master A write data |
| b_wr_en | input | 1 | Master B write strobe |
| b_wr_idx | input | IDX_W | Master B register index |
| b_wr_data | input | DATA_W | Master B write data |
| rd_idx | input | IDX_W | Read register index |
| rd_data | output | DATA_W | Selected register contents |
| status | output | 2*(NUM_RES+NUM_GRP) | Packed current value of every field |
| prev_owner | output | 2*(NUM_RES+NUM_GRP) | Packed previous value of every field |

## Verification
The bench attacks a held field with a nonzero write from each master. A design that let a second claim through would hand one resource to both owners at once.

It writes the group register with 11 in every field but one. A design that treated 11 as an ordinary code would corrupt neighbouring groups, or would lock a free group into the 11 state.

Same-cycle collisions check the A-then-B ordering. One collision is A releasing while B claims, which must end owned by B. A design that evaluated both writes against the old value would leave the field held by A, or would drop B's claim.

The bench also confirms that ignored writes and out-of-range indices leave the previous-owner slices untouched. A random mix of writes from both masters is then compared against a reference model.

// File: rtl/sema_pkg.sv
`timescale 1ns/1ps
package sema_pkg;

    typedef logic [1:0] own_t;

    localparam own_t OWN_FREE = 2'b00;
    localparam own_t OWN_KEEP = 2'b11;

    // Next value of one field after a single write of code.
    function automatic own_t sema_apply(own_t cur, own_t code, logic keep_en);
        own_t nxt;
        if (keep_en && code == OWN_KEEP) begin
            nxt = cur;
        end else if (cur == OWN_FREE) begin
            nxt = code;
        end else if (code == OWN_FREE) begin
            nxt = OWN_FREE;
        end else begin
            nxt = cur;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/sema_field.sv
`timescale 1ns/1ps
module sema_field
    import sema_pkg::*;
#(
    parameter bit HAS_KEEP = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic a_hit,
    input  own_t a_code,
    input  logic b_hit,
    input  own_t b_code,
    output own_t state_o,
    output own_t prev_o
);

    typedef struct packed {
        own_t st;
        own_t pv;
    } fld_t;

    fld_t fld_d, fld_q;
    own_t mid_val, fin_val;

    always_comb begin
        mid_val  = a_hit ? sema_apply(fld_q.st, a_code, HAS_KEEP) : fld_q.st;
        fin_val  = b_hit ? sema_apply(mid_val, b_code, HAS_KEEP) : mid_val;
        fld_d.st = fin_val;
        fld_d.pv = (fin_val != fld_q.st) ? fld_q.st : fld_q.pv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fld_q <= '0;
        end else begin
            fld_q <= fld_d;
        end
    end

    assign state_o = fld_q.st;
    assign prev_o  = fld_q.pv;

endmodule

// File: rtl/sema_rd_mux.sv
`timescale 1ns/1ps
module sema_rd_mux #(
    parameter int NUM_RES = 3,
    parameter int NUM_GRP = 5,
    parameter int IDX_W   = 3,
    localparam int DATA_W = 2 * NUM_GRP,
    localparam int SW     = 2 * (NUM_RES + NUM_GRP)
) (
    input  logic [SW-1:0]     status_i,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_RES; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data[1:0] = status_i[2*i +: 2];
            end
        end
        if (rd_idx == IDX_W'(NUM_RES)) begin
            rd_data = status_i[2*NUM_RES +: DATA_W];
        end
    end

endmodule

// File: rtl/hw_sema_bank.sv
`timescale 1ns/1ps
module hw_sema_bank
    import sema_pkg::*;
#(
    parameter int NUM_RES = 3,
    parameter int NUM_GRP = 5,
    localparam int NUM_FLD = NUM_RES + NUM_GRP,
    localparam int DATA_W  = 2 * NUM_GRP,
    localparam int SW      = 2 * NUM_FLD,
    localparam int IDX_W   = $clog2(NUM_RES + 1) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_wr_en,
    input  logic [IDX_W-1:0]  a_wr_idx,
    input  logic [DATA_W-1:0] a_wr_data,
    input  logic              b_wr_en,
    input  logic [IDX_W-1:0]  b_wr_idx,
    input  logic [DATA_W-1:0] b_wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [SW-1:0]     status,
    output logic [SW-1:0]     prev_owner
);

    for (genvar f = 0; f < NUM_FLD; f++) begin : g_fld
        logic a_hit, b_hit;
        own_t a_code, b_code, st, pv;

        if (f < NUM_RES) begin : g_single
            assign a_hit  = a_wr_en && (a_wr_idx == IDX_W'(f));
            assign b_hit  = b_wr_en && (b_wr_idx == IDX_W'(f));
            assign a_code = a_wr_data[1:0];
            assign b_code = b_wr_data[1:0];
        end else begin : g_group
            assign a_hit  = a_wr_en && (a_wr_idx == IDX_W'(NUM_RES));
            assign b_hit  = b_wr_en && (b_wr_idx == IDX_W'(NUM_RES));
            assign a_code = a_wr_data[2*(f-NUM_RES) +: 2];
            assign b_code = b_wr_data[2*(f-NUM_RES) +: 2];
        end

        sema_field #(
            .HAS_KEEP(f >= NUM_RES)
        ) u_field (
            .clk    (clk),
            .rst_n  (rst_n),
            .a_hit  (a_hit),
            .a_code (a_code),
            .b_hit  (b_hit),
            .b_code (b_code),
            .state_o(st),
            .prev_o (pv)
        );

        assign status[2*f +: 2]     = st;
        assign prev_owner[2*f +: 2] = pv;
    end

    sema_rd_mux #(
        .NUM_RES(NUM_RES),
        .NUM_GRP(NUM_GRP),
        .IDX_W  (IDX_W)
    ) u_rd (
        .status_i(status),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/sema_bank_chk.sv
`timescale 1ns/1ps
module sema_bank_chk #(
    parameter int NUM_RES = 3,
    parameter int NUM_GRP = 5,
    parameter int IDX_W   = 3,
    localparam int DATA_W = 2 * NUM_GRP,
    localparam int SW     = 2 * (NUM_RES + NUM_GRP),
    localparam int GS     = 2 * NUM_RES
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_wr_en,
    input logic [IDX_W-1:0]  a_wr_idx,
    input logic [DATA_W-1:0] a_wr_data,
    input logic              b_wr_en,
    input logic [IDX_W-1:0]  b_wr_idx,
    input logic [DATA_W-1:0] b_wr_data,
    input logic [IDX_W-1:0]  rd_idx,
    input logic [DATA_W-1:0] rd_data,
    input logic [SW-1:0]     status,
    input logic [SW-1:0]     prev_owner
);

    logic a0, b0, ag, bg;
    assign a0 = a_wr_en && (a_wr_idx == '0);
    assign b0 = b_wr_en && (b_wr_idx == '0);
    assign ag = a_wr_en && (a_wr_idx == IDX_W'(NUM_RES));
    assign bg = b_wr_en && (b_wr_idx == IDX_W'(NUM_RES));

    AST_FREE_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1:0] == 2'b00 && a0 && !b0) |=> (status[1:0] == $past(a_wr_data[1:0]))); // R2

    AST_HELD_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1:0] != 2'b00 && a0 && a_wr_data[1:0] != 2'b00 && !b0) |=> (status[1:0] == $past(status[1:0]))); // R3

    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1:0] != 2'b00 && a0 && a_wr_data[1:0] == 2'b00 && !b0) |=> (status[1:0] == 2'b00)); // R4

    AST_GROUP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ag && a_wr_data[1:0] == 2'b11 && !bg) |=> $stable(status[GS +: 2])); // R5

    AST_PREV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (status == $past(status)) |-> (prev_owner == $past(prev_owner))); // R7

    AST_PREV_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1:0] != $past(status[1:0])) |-> (prev_owner[1:0] == $past(status[1:0]))); // R7

    AST_A_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1:0] == 2'b00 && a0 && a_wr_data[1:0] == 2'b01 && b0 && b_wr_data[1:0] == 2'b10)
        |=> (status[1:0] == 2'b01)); // R8

    AST_RD_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == IDX_W'(NUM_RES)) |-> (rd_data == status[GS +: DATA_W])); // R9

    AST_RD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx > IDX_W'(NUM_RES)) |-> (rd_data == '0)); // R9

endmodule

bind hw_sema_bank sema_bank_chk #(
    .NUM_RES(NUM_RES),
    .NUM_GRP(NUM_GRP),
    .IDX_W  (IDX_W)
) u_chk (.*);

// File: tb/tb_hw_sema_bank.sv
`timescale 1ns/1ps
module tb_hw_sema_bank;

    localparam int NR = 3;
    localparam int NG = 5;
    localparam int NF = NR + NG;
    localparam int DW = 2 * NG;
    localparam int SW = 2 * NF;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          a_wr_en = 1'b0, b_wr_en = 1'b0;
    logic [IW-1:0] a_wr_idx = '0, b_wr_idx = '0, rd_idx = '0;
    logic [DW-1:0] a_wr_data = '0, b_wr_data = '0;
    logic [DW-1:0] rd_data;
    logic [SW-1:0] status, prev_owner;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [1:0] m_st [NF];
    logic [1:0] m_pv [NF];

    always #2 clk = ~clk;

    hw_sema_bank #(.NUM_RES(NR), .NUM_GRP(NG)) dut (
        .clk(clk), .rst_n(rst_n),
        .a_wr_en(a_wr_en), .a_wr_idx(a_wr_idx), .a_wr_data(a_wr_data),
        .b_wr_en(b_wr_en), .b_wr_idx(b_wr_idx), .b_wr_data(b_wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .status(status), .prev_owner(prev_owner)
    );

    function automatic logic [1:0] nxt(logic [1:0] cur, logic [1:0] code, bit grp);
        if (grp && code == 2'b11) return cur;
        if (cur == 2'b00) return code;
        if (code == 2'b00) return 2'b00;
        return cur;
    endfunction

    function automatic logic [SW-1:0] pack_st();
        logic [SW-1:0] v;
        for (int f = 0; f < NF; f++) v[2*f +: 2] = m_st[f];
        return v;
    endfunction

    function automatic logic [SW-1:0] pack_pv();
        logic [SW-1:0] v;
        for (int f = 0; f < NF; f++) v[2*f +: 2] = m_pv[f];
        return v;
    endfunction

    function automatic logic [DW-1:0] exp_rd(logic [IW-1:0] idx);
        logic [DW-1:0] v = '0;
        if (int'(idx) < NR) v[1:0] = m_st[idx];
        else if (int'(idx) == NR) for (int k = 0; k < NG; k++) v[2*k +: 2] = m_st[NR+k];
        return v;
    endfunction

    task automatic chk(string tag, logic [SW-1:0] act, logic [SW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply one write cycle from both ports; leaves time just after the next negedge.
    task automatic step(bit ae, int ai, logic [DW-1:0] ad, bit be, int bi, logic [DW-1:0] bd);
        logic [1:0] cur, mid, fin, ca, cb;
        bit ha, hb, grp;
        a_wr_en = ae; a_wr_idx = IW'(ai); a_wr_data = ad;
        b_wr_en = be; b_wr_idx = IW'(bi); b_wr_data = bd;
        for (int f = 0; f < NF; f++) begin
            grp = (f >= NR);
            ha  = ae && (grp ? ai == NR : ai == f);
            hb  = be && (grp ? bi == NR : bi == f);
            ca  = grp ? ad[2*(f-NR) +: 2] : ad[1:0];
            cb  = grp ? bd[2*(f-NR) +: 2] : bd[1:0];
            cur = m_st[f];
            mid = ha ? nxt(cur, ca, grp) : cur;
            fin = hb ? nxt(mid, cb, grp) : mid;
            if (fin != cur) m_pv[f] = cur;
            m_st[f] = fin;
        end
        @(posedge clk);
        #1;
        a_wr_en = 1'b0; b_wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic chk_all(string tag);
        chk({tag, " R6 status"}, status, pack_st());
        chk({tag, " R7 prev"}, prev_owner, pack_pv());
    endtask

    task automatic chk_rd(string tag, int idx);
        rd_idx = IW'(idx);
        #1;
        chk({tag, " R9 rd_data"}, SW'(rd_data), SW'(exp_rd(IW'(idx))));
    endtask

    initial begin
        for (int f = 0; f < NF; f++) begin m_st[f] = 2'b00; m_pv[f] = 2'b00; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);

        chk("R1 reset status", status, '0);
        chk("R1 reset prev", prev_owner, '0);
        chk_rd("R1", NR);

        step(1, 0, 10'h001, 0, 0, '0);
        chk("R2 A claims sem0", SW'(status[1:0]), SW'(2'b01));
        step(0, 0, '0, 1, 1, 10'h002);
        chk("R2 B claims sem1", SW'(status[3:2]), SW'(2'b10));
        chk_all("R2");

        step(0, 0, '0, 1, 0, 10'h002);
        chk("R3 B claim on held sem0", SW'(status[1:0]), SW'(2'b01));
        step(1, 0, 10'h003, 0, 0, '0);
        chk("R3 code 11 on held sem0", SW'(status[1:0]), SW'(2'b01));
        chk("R7 prev untouched by ignored write", SW'(prev_owner[1:0]), SW'(2'b00));

        step(1, 0, 10'h000, 0, 0, '0);
        chk("R4 release sem0", SW'(status[1:0]), SW'(2'b00));
        chk("R7 prev records A", SW'(prev_owner[1:0]), SW'(2'b01));
        step(1, 1, 10'h000, 0, 0, '0);
        chk("R4 A releases B-held sem1", SW'(status[3:2]), SW'(2'b00));

        step(0, 0, '0, 1, NR, 10'b11_1111_1011);
        chk("R5 B claims group1", status, SW'(16'b0000_0010_0000_0000));
        chk_rd("R5", NR);
        step(1, NR, 10'b11_1111_1101, 0, 0, '0);
        chk("R5 A claims group0", SW'(status[7:6]), SW'(2'b01));
        step(1, NR, 10'b11_1111_0011, 0, 0, '0);
        chk("R5 release group1", SW'(status[9:8]), SW'(2'b00));
        chk("R5 group0 untouched", SW'(status[7:6]), SW'(2'b01));
        chk("R7 prev group1", SW'(prev_owner[9:8]), SW'(2'b10));

        step(1, 2, 10'h001, 1, 2, 10'h002);
        chk("R8 A wins free collision", SW'(status[5:4]), SW'(2'b01));
        step(1, 2, 10'h000, 1, 2, 10'h002);
        chk("R8 A release then B claim", SW'(status[5:4]), SW'(2'b10));
        chk("R8 prev after handover", SW'(prev_owner[5:4]), SW'(2'b01));
        chk_all("R8");

        chk_rd("R9 idx2", 2);
        chk_rd("R9 idx5", 5);
        step(1, 5, 10'h155, 1, 7, 10'h2AA);
        chk_all("R10 out-of-range write");
        chk_rd("R10", NR);

        begin
            int unsigned seed = 32'h5EA1;
            void'($urandom(seed));
            for (int n = 0; n < 600; n++) begin
                step($urandom % 2, $urandom % 5, DW'($urandom),
                     $urandom % 2, $urandom % 5, DW'($urandom));
                chk_all("random");
                chk_rd("random", $urandom % 6);
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule